// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block carries out the two privileged return operations of a RISC-V style core: the return from a supervisor trap handler and the return from a machine trap handler. The core presents a single-cycle request that names the kind of return. With it come the current privilege level, the status word, both saved exception PCs, a flag that says whether compressed instructions are enabled, and a flag that selects the older status-update convention.

One clock after the request, the block gives exactly one of two results. The first is a committed return, which carries the target PC, the rewritten status word and the privilege level to resume in. The second is an exception, which carries a cause code. On an exception the committed outputs keep their earlier values.

A small controller with three states drives the result: `ST_IDLE`, `ST_COMMIT` and `ST_FAULT`. In any state, a request whose checks pass moves the controller to `ST_COMMIT` (transition *accept*). A request that fails a check moves it to `ST_FAULT` (transition *reject*). A cycle with no request moves it to `ST_IDLE` (transition *settle*). Back-to-back requests therefore yield back-to-back results.

Top module: `priv_return_unit`

## Requirements
- R1: A supervisor return (`req_is_mret`=0) with `cur_priv` equal to user (0) raises an exception with cause 2 (illegal instruction).
- R2: A machine return (`req_is_mret`=1) with `cur_priv` other than machine (3) raises an exception with cause 2.
- R3: On commit, `new_pc` equals `sepc_in` for a supervisor return and `mepc_in` for a machine return, sampled in the request cycle.
- R4: When `rvc_en` is 0 and bits [1:0] of the selected return PC are not both zero, the block raises cause 0 (misaligned fetch) and does not commit. When `rvc_en` is 1, the alignment check is skipped.
- R5: When a request is both illegal and misaligned, the cause is 2.
- R6: On commit, `new_priv` is taken from status bit 8 (zero-extended) for a supervisor return, or from status bits [12:11] for a machine return. Privilege encodings are user=0, supervisor=1 and machine=3.
- R7: With `legacy_mode`=0, the return copies status bit 5 into bit 1 for a supervisor return, and copies status bit 7 into bit 3 for a machine return.
- R8: With `legacy_mode`=1, the previous-enable bit (5 or 7) is written into the status bit whose index equals the restored privilege, and bits 1 and 3 are not otherwise changed.
- R9: On commit, the return clears the previous-enable bit (5 or 7) and zeroes the previous-privilege field (bit 8, or bits [12:11]). All other status bits pass through unchanged.
- R10: Each request produces a one-cycle `done` pulse in the next cycle, with exactly one of `commit` or `excp` high. No `done` appears without a request.
- R11: On an exception, `new_pc`, `new_status` and `new_priv` keep the values they held before.
- R12: After reset, `done`, `commit` and `excp` are 0, `new_pc` and `new_status` are 0, and `new_priv` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle return request |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| status_in | input | XLEN | Current status word |
| sepc_in | input | XLEN | Saved supervisor exception PC |
| mepc_in | input | XLEN | Saved machine exception PC |
| rvc_en | input | 1 | Compressed instructions enabled |
| legacy_mode | input | 1 | Selects the older enable-restore convention |
| done | output | 1 | Result valid pulse |
| commit | output | 1 | Return committed |
| excp | output | 1 | Return rejected with exception |
| excp_cause | output | 4 | Exception cause code (valid with excp) |
| new_pc | output | XLEN | Return target PC |
| new_status | output | XLEN | Rewritten status word |
| new_priv | output | 2 | Privilege level to resume in |

## Verification
Several rules are checked by assertions on every cycle. `done` follows a request by exactly one cycle and never appears without one, and commit and exception are never high together. The illegal-privilege cases always map to cause 2, and an alignment fault always maps to cause 0. A committed return takes the right saved PC and clears the previous fields, and the outputs stay frozen through an exception. The bench scenarios cover what a property cannot easily state: the full status rewrite in both conventions, including the legacy write into bit 0 or bit 1, the priority of the two faults, and the held values seen across sequences of mixed accepts and rejects.

// File: rtl/pru_pkg.sv
package pru_pkg;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGNED = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL    = 4'd2;

    localparam int BIT_SIE    = 1;
    localparam int BIT_MIE    = 3;
    localparam int BIT_SPIE   = 5;
    localparam int BIT_MPIE   = 7;
    localparam int BIT_SPP    = 8;
    localparam int BIT_MPP_LO = 11;
    localparam int BIT_MPP_HI = 12;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VERDICT_OK       = 2'd0,
        VERDICT_ILLEGAL  = 2'd1,
        VERDICT_MISALIGN = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FAULT  = 2'd2
    } pru_state_e;

endpackage

// File: rtl/pru_check.sv
module pru_check
    import pru_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            is_mret,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] sepc,
    input  logic [XLEN-1:0] mepc,
    input  logic            rvc_en,
    output logic [XLEN-1:0] ret_pc,
    output verdict_e        verdict
);

    localparam priv_e MIN_S = PRIV_S;
    localparam priv_e MIN_M = PRIV_M;

    logic priv_low;
    logic addr_odd;

    always_comb begin
        ret_pc   = is_mret ? mepc : sepc;
        priv_low = is_mret ? (cur_priv < MIN_M) : (cur_priv < MIN_S);
    end

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign addr_odd = !rvc_en && (ret_pc[ALIGN_BITS-1:0] != '0);
        end else begin : g_noalign
            assign addr_odd = 1'b0;
        end
    endgenerate

    // Privilege fault outranks alignment fault
    always_comb begin
        if (priv_low)
            verdict = VERDICT_ILLEGAL;
        else if (addr_odd)
            verdict = VERDICT_MISALIGN;
        else
            verdict = VERDICT_OK;
    end

endmodule

// File: rtl/pru_status_xform.sv
module pru_status_xform
    import pru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            is_mret,
    input  logic            legacy_mode,
    input  logic [XLEN-1:0] status_in,
    output logic [XLEN-1:0] status_out,
    output logic [1:0]      priv_out
);

    logic [1:0] prev_pp;
    logic       prev_pie;

    always_comb begin
        if (is_mret) begin
            prev_pp  = status_in[BIT_MPP_HI:BIT_MPP_LO];
            prev_pie = status_in[BIT_MPIE];
        end else begin
            prev_pp  = {1'b0, status_in[BIT_SPP]};
            prev_pie = status_in[BIT_SPIE];
        end
    end

    always_comb begin
        status_out = status_in;
        if (legacy_mode)
            status_out[prev_pp] = prev_pie;
        else if (is_mret)
            status_out[BIT_MIE] = prev_pie;
        else
            status_out[BIT_SIE] = prev_pie;

        if (is_mret) begin
            status_out[BIT_MPIE]              = 1'b0;
            status_out[BIT_MPP_HI:BIT_MPP_LO] = PRIV_U;
        end else begin
            status_out[BIT_SPIE] = 1'b0;
            status_out[BIT_SPP]  = 1'b0;
        end
        priv_out = prev_pp;
    end

endmodule

// File: rtl/pru_ctrl.sv
module pru_ctrl
    import pru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  verdict_e           verdict,
    input  logic [XLEN-1:0]    ret_pc,
    input  logic [XLEN-1:0]    calc_status,
    input  logic [1:0]         calc_priv,
    output logic               done,
    output logic               commit,
    output logic               excp,
    output logic [CAUSE_W-1:0] excp_cause,
    output logic [XLEN-1:0]    new_pc,
    output logic [XLEN-1:0]    new_status,
    output logic [1:0]         new_priv
);

    pru_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_COMMIT, ST_FAULT: begin
                if (req_valid)
                    state_d = (verdict == VERDICT_OK) ? ST_COMMIT : ST_FAULT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        done   = 1'b0;
        commit = 1'b0;
        excp   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: begin done = 1'b1; commit = 1'b1; end
            ST_FAULT:  begin done = 1'b1; excp   = 1'b1; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_pc     <= '0;
            new_status <= '0;
            new_priv   <= PRIV_M;
            excp_cause <= '0;
        end else if (req_valid) begin
            if (verdict == VERDICT_OK) begin
                new_pc     <= ret_pc;
                new_status <= calc_status;
                new_priv   <= calc_priv;
            end else begin
                excp_cause <= (verdict == VERDICT_ILLEGAL) ? CAUSE_ILLEGAL
                                                           : CAUSE_MISALIGNED;
            end
        end
    end

endmodule

// File: rtl/priv_return_unit.sv
module priv_return_unit
    import pru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_is_mret,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] sepc_in,
    input  logic [XLEN-1:0] mepc_in,
    input  logic            rvc_en,
    input  logic            legacy_mode,
    output logic            done,
    output logic            commit,
    output logic            excp,
    output logic [3:0]      excp_cause,
    output logic [XLEN-1:0] new_pc,
    output logic [XLEN-1:0] new_status,
    output logic [1:0]      new_priv
);

    logic [XLEN-1:0] ret_pc;
    logic [XLEN-1:0] calc_status;
    logic [1:0]      calc_priv;
    verdict_e        verdict;

    pru_check #(.XLEN(XLEN), .ALIGN_BITS(2)) u_check (
        .is_mret  (req_is_mret),
        .cur_priv (cur_priv),
        .sepc     (sepc_in),
        .mepc     (mepc_in),
        .rvc_en   (rvc_en),
        .ret_pc   (ret_pc),
        .verdict  (verdict)
    );

    pru_status_xform #(.XLEN(XLEN)) u_xform (
        .is_mret     (req_is_mret),
        .legacy_mode (legacy_mode),
        .status_in   (status_in),
        .status_out  (calc_status),
        .priv_out    (calc_priv)
    );

    pru_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .verdict     (verdict),
        .ret_pc      (ret_pc),
        .calc_status (calc_status),
        .calc_priv   (calc_priv),
        .done        (done),
        .commit      (commit),
        .excp        (excp),
        .excp_cause  (excp_cause),
        .new_pc      (new_pc),
        .new_status  (new_status),
        .new_priv    (new_priv)
    );

endmodule

// File: rtl/pru_sva.sv
module pru_sva #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_is_mret,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] sepc_in,
    input logic [XLEN-1:0] mepc_in,
    input logic            rvc_en,
    input logic            done,
    input logic            commit,
    input logic            excp,
    input logic [3:0]      excp_cause,
    input logic [XLEN-1:0] new_pc,
    input logic [XLEN-1:0] new_status,
    input logic [1:0]      new_priv
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && excp)); // R10

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R10

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done); // R10

    AST_SRET_LOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mret && cur_priv == 2'd0)
        |=> (excp && excp_cause == 4'd2)); // R1

    AST_MRET_LOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mret && cur_priv != 2'd3)
        |=> (excp && excp_cause == 4'd2)); // R2

    AST_MISALIGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rvc_en && ((req_is_mret && cur_priv == 2'd3
            && mepc_in[1:0] != 2'b00) || (!req_is_mret && cur_priv != 2'd0
            && sepc_in[1:0] != 2'b00)))
        |=> (excp && excp_cause == 4'd0)); // R4

    AST_MRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mret) |=> (!commit || new_pc == $past(mepc_in))); // R3

    AST_SRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mret) |=> (!commit || new_pc == $past(sepc_in))); // R3

    AST_MRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mret)
        |=> (!commit || (!new_status[7] && new_status[12:11] == 2'b00))); // R9

    AST_SRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mret)
        |=> (!commit || (!new_status[5] && !new_status[8]))); // R9

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        excp |-> ($stable(new_pc) && $stable(new_status) && $stable(new_priv))); // R11

endmodule

bind priv_return_unit pru_sva #(.XLEN(XLEN)) u_sva (.*);

// File: tb/sim_priv_return_unit.sv
`timescale 1ns/1ps
module sim_priv_return_unit;

    localparam int XLEN = 32;

    typedef struct {
        logic            commit;
        logic [3:0]      cause;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] status;
        logic [1:0]      priv;
        int              cyc;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_is_mret = 1'b0;
    logic [1:0]      cur_priv = 2'd0;
    logic [XLEN-1:0] status_in = '0;
    logic [XLEN-1:0] sepc_in = '0;
    logic [XLEN-1:0] mepc_in = '0;
    logic            rvc_en = 1'b0;
    logic            legacy_mode = 1'b0;
    logic            done, commit, excp;
    logic [3:0]      excp_cause;
    logic [XLEN-1:0] new_pc, new_status;
    logic [1:0]      new_priv;

    int total = 0;
    int bad = 0;
    int cycle = 0;
    exp_t sb[$];
    logic [XLEN-1:0] held_pc = '0;
    logic [XLEN-1:0] held_status = '0;
    logic [1:0]      held_priv = 2'd3;
    logic [31:0]     lfsr = 32'hACE1_2468;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    priv_return_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mret(req_is_mret),
        .cur_priv(cur_priv), .status_in(status_in), .sepc_in(sepc_in),
        .mepc_in(mepc_in), .rvc_en(rvc_en), .legacy_mode(legacy_mode),
        .done(done), .commit(commit), .excp(excp), .excp_cause(excp_cause),
        .new_pc(new_pc), .new_status(new_status), .new_priv(new_priv)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: applies one request and pushes its expected result
    task automatic issue(input logic is_m, input logic [1:0] pv, input logic [XLEN-1:0] st,
                         input logic [XLEN-1:0] sp, input logic [XLEN-1:0] mp,
                         input logic rvc, input logic leg, input string tag);
        exp_t e;
        logic [XLEN-1:0] pc, ns;
        logic [1:0] pp;
        logic pie, illegal, mis;
        @(negedge clk);
        req_valid = 1'b1; req_is_mret = is_m; cur_priv = pv; status_in = st;
        sepc_in = sp; mepc_in = mp; rvc_en = rvc; legacy_mode = leg;
        illegal = is_m ? (pv != 2'd3) : (pv == 2'd0);
        pc  = is_m ? mp : sp;
        mis = !rvc && (pc[1:0] != 2'b00);
        pp  = is_m ? st[12:11] : {1'b0, st[8]};
        pie = is_m ? st[7] : st[5];
        ns  = st;
        if (leg) ns[pp] = pie;
        else if (is_m) ns[3] = pie;
        else ns[1] = pie;
        if (is_m) begin ns[7] = 1'b0; ns[12:11] = 2'b00; end
        else begin ns[5] = 1'b0; ns[8] = 1'b0; end
        e.cyc = cycle;
        e.tag = tag;
        if (illegal || mis) begin
            e.commit = 1'b0;
            e.cause  = illegal ? 4'd2 : 4'd0;
        end else begin
            e.commit = 1'b1;
            e.cause  = 4'd0;
            held_pc = pc; held_status = ns; held_priv = pp;
        end
        e.pc = held_pc; e.status = held_status; e.priv = held_priv;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 64'(done), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(commit == e.commit, {e.tag, " R10 commit"}, 64'(commit), 64'(e.commit));
                    chk(excp == !e.commit, {e.tag, " R10 excp"}, 64'(excp), 64'(!e.commit));
                    if (!e.commit)
                        chk(excp_cause == e.cause, {e.tag, " cause"}, 64'(excp_cause), 64'(e.cause));
                    chk(new_pc == e.pc, {e.tag, e.commit ? " R3 pc" : " R11 pc"}, 64'(new_pc), 64'(e.pc));
                    chk(new_status == e.status, {e.tag, e.commit ? " status" : " R11 status"},
                        64'(new_status), 64'(e.status));
                    chk(new_priv == e.priv, {e.tag, e.commit ? " R6 priv" : " R11 priv"},
                        64'(new_priv), 64'(e.priv));
                end
            end else if (sb.size() != 0 && cycle > sb[0].cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(1'b0, {e.tag, " R10 missing done"}, 64'(done), 64'd1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && commit == 1'b0 && excp == 1'b0, "R12 flags", {61'd0, done, commit, excp}, 64'd0);
        chk(new_pc == '0, "R12 pc", 64'(new_pc), 64'd0);
        chk(new_status == '0, "R12 status", 64'(new_status), 64'd0);
        chk(new_priv == 2'd3, "R12 priv", 64'(new_priv), 64'd3);

        issue(1'b0, 2'd0, 32'h0000_0122, 32'h100, 32'h200, 1'b0, 1'b0, "R1");
        idle(2);
        issue(1'b1, 2'd1, 32'h0000_1880, 32'h100, 32'h200, 1'b0, 1'b0, "R2");
        issue(1'b1, 2'd2, 32'h0000_1880, 32'h100, 32'h200, 1'b0, 1'b0, "R2");
        issue(1'b0, 2'd1, 32'h0000_0120, 32'h4000_1000, 32'h200, 1'b0, 1'b0, "R7");
        issue(1'b1, 2'd3, 32'h0000_0808, 32'h100, 32'h8000_0040, 1'b0, 1'b0, "R7");
        issue(1'b1, 2'd3, 32'h0000_1888, 32'h100, 32'h0000_0300, 1'b1, 1'b0, "R6");
        issue(1'b1, 2'd3, 32'h0000_0880, 32'h100, 32'h0000_0500, 1'b0, 1'b1, "R8");
        issue(1'b0, 2'd3, 32'h0000_0023, 32'h0000_0700, 32'h100, 1'b0, 1'b1, "R8");
        issue(1'b0, 2'd1, 32'h0000_0120, 32'h0000_0902, 32'h100, 1'b0, 1'b0, "R4");
        issue(1'b0, 2'd1, 32'hFFFF_FFFF, 32'h0000_0A02, 32'h100, 1'b1, 1'b0, "R4");
        issue(1'b1, 2'd3, 32'hFFFF_FFFF, 32'h100, 32'h0000_0B01, 1'b0, 1'b0, "R4");
        issue(1'b0, 2'd0, 32'h0000_0120, 32'h0000_0C03, 32'h100, 1'b0, 1'b0, "R5");
        issue(1'b1, 2'd1, 32'h0000_1880, 32'h100, 32'h0000_0D02, 1'b0, 1'b1, "R5");
        issue(1'b1, 2'd3, 32'h0000_1880, 32'h100, 32'h0000_0E00, 1'b0, 1'b1, "R9");
        idle(3);
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            issue(lfsr[3], lfsr[5:4], {lfsr[15:0], lfsr[31:16]}, {lfsr[27:4], lfsr[7:0]},
                  {lfsr[19:0], lfsr[31:20]}, lfsr[9], lfsr[11], "R9 rand");
            if (lfsr[13]) idle(1);
        end
        idle(4);
        chk(sb.size() == 0, "R10 drained", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule